// File: doc/BRIEF.md
# Memory Pointer and Auxiliary Pointer File

This unit holds the 16-bit byte address that a microsequenced datapath uses for every memory access. It also holds a file of thirty-two 16-bit auxiliary registers that park pointer values, so that the datapath does not have to save them to memory. In one cycle the unit can move a value between the pointer and any auxiliary register in either direction, swap the two, or load the pointer from an immediate. A move from the pointer into the file can also shift the stored value by up to three bytes either way, which lets a pointer be advanced while it is saved.

Operand selects on the register bus can request a one-byte step of the pointer as a side effect. The step is suppressed when the datapath runs in its 16-bit extended mode. From the current pointer the unit forms two byte addresses: the addressed byte and its partner in the same 16-bit word. A two-byte read uses both, and a write strobe selects one of them. The memory array and the ALU sit outside this unit. The ALU reaches the pointer only through the high and low byte-write ports.

Top module: `ptr_aux_unit`

## Requirements
- R1: After reset the pointer is 0x0000 and all 32 auxiliary registers read 0x0000.
- R2: With op_i = 1 (auxiliary to pointer), the pointer takes the value of auxiliary register aux_idx_i at the next clock edge. adj_i has no effect on this move.
- R3: With op_i = 2 (pointer to auxiliary), register aux_idx_i takes the pointer adjusted by adj_i, and the pointer is unchanged. adj_i is sign-magnitude: bit 2 set means subtract and bits 1:0 give the amount 0..3, so 100 and 000 both mean no change.
- R4: With op_i = 3 (exchange), the pointer takes the old value of register aux_idx_i. In the same edge, that register takes the old pointer adjusted as in R3.
- R5: With op_i = 4 (immediate load), the pointer takes imm_i. op_i = 0 requests no transfer.
- R6: rd_hi_addr_o equals the pointer and rd_lo_addr_o equals the pointer with bit 0 inverted. mem_rd_o is 1 exactly when dd_i = 01.
- R7: dd_i = 10 asserts mem_wr_o with mem_wr_addr_o equal to the pointer. dd_i = 11 asserts mem_wr_o with the pointer with bit 0 inverted. dd_i = 00 and dd_i = 01 leave mem_wr_o at 0.
- R8: When asel_vld_i is 1, asel_i codes 1000, 1001 and 1111 decrement the pointer by 1 and codes 1100, 1101 and 1110 increment it by 1. All other codes leave it unchanged.
- R9: When ext_i is 1, the step of R8 is suppressed and the pointer holds.
- R10: All pointer and adjust arithmetic wraps modulo 2^16.
- R11: A transfer (op_i not 0) takes precedence over byte writes and steps in the same cycle. A byte write takes precedence over a step.
- R12: hi_we_i loads hi_wdata_i into pointer bits 15:8 and lo_we_i loads lo_wdata_i into bits 7:0. A byte that is not written keeps its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| op_i | input | 3 | Transfer code: 0 none, 1 aux to pointer, 2 pointer to aux, 3 exchange, 4 immediate |
| aux_idx_i | input | 5 | Auxiliary register index |
| adj_i | input | 3 | Sign-magnitude adjust for values written into the file |
| imm_i | input | 16 | Immediate pointer value |
| hi_we_i | input | 1 | Write enable for the pointer high byte |
| lo_we_i | input | 1 | Write enable for the pointer low byte |
| hi_wdata_i | input | 8 | High byte data |
| lo_wdata_i | input | 8 | Low byte data |
| asel_vld_i | input | 1 | Register-bus operand select is active |
| asel_i | input | 4 | Operand select code |
| ext_i | input | 1 | 16-bit extended mode |
| dd_i | input | 2 | Memory access kind: 00 none, 01 read, 10 write at pointer, 11 write at partner |
| ptr_o | output | 16 | Current pointer |
| aux_rd_o | output | 16 | Value of auxiliary register aux_idx_i |
| rd_hi_addr_o | output | 16 | Address of the byte for the high read-data register |
| rd_lo_addr_o | output | 16 | Address of the byte for the low read-data register |
| mem_rd_o | output | 1 | Two-byte read strobe |
| mem_wr_o | output | 1 | Byte write strobe |
| mem_wr_addr_o | output | 16 | Byte write address |

## Verification
Pointer values next to 0x0000 and 0xFFFF are driven with every adjust code and both step directions. This shows modular wrap apart from saturation, and a sign-magnitude adjust apart from a two's-complement one. The step codes are swept one by one with the mode flag both clear and set, which separates increment, decrement and hold codes and confirms the suppression. Transfers, byte writes and steps are then requested in the same cycle so that the priority order can be seen in the result. A long random mix of all inputs is checked against a behavioural model on every cycle. This covers exchanges whose old pointer and old register value differ, and even and odd pointers for the partner-address logic.

// File: rtl/ptr_aux_pkg.sv
package ptr_aux_pkg;

  typedef enum logic [2:0] {
    OP_NONE = 3'd0,
    OP_A2P  = 3'd1,
    OP_P2A  = 3'd2,
    OP_XCHG = 3'd3,
    OP_LDI  = 3'd4
  } ptr_op_e;

  localparam logic [1:0] DD_NONE = 2'b00;
  localparam logic [1:0] DD_READ = 2'b01;
  localparam logic [1:0] DD_WR1  = 2'b10;
  localparam logic [1:0] DD_WR2  = 2'b11;

  // Sign-magnitude adjust: bit 2 selects subtract, bits 1:0 give the amount.
  function automatic logic [15:0] apply_adjust(input logic [15:0] v,
                                               input logic [2:0] code);
    logic [15:0] mag;
    mag = {14'd0, code[1:0]};
    return code[2] ? (v - mag) : (v + mag);
  endfunction

  // Operand-select step: returns {decrement, increment}.
  function automatic logic [1:0] step_kind(input logic [3:0] sel);
    case (sel)
      4'b1000, 4'b1001, 4'b1111: return 2'b10;
      4'b1100, 4'b1101, 4'b1110: return 2'b01;
      default:                   return 2'b00;
    endcase
  endfunction

endpackage

// File: rtl/ptr_step_decode.sv
module ptr_step_decode
  import ptr_aux_pkg::*;
#(
  parameter int SELW = 4
) (
  input  logic [SELW-1:0] sel_i,
  input  logic            vld_i,
  input  logic            ext_i,
  output logic            inc_o,
  output logic            dec_o
);
  logic [1:0] kind;
  logic       live;

  always_comb begin
    kind  = step_kind(sel_i);
    live  = vld_i && !ext_i;
    inc_o = live && kind[0];
    dec_o = live && kind[1];
  end
endmodule

// File: rtl/ptr_aux_file.sv
module ptr_aux_file #(
  parameter int ENTRIES = 32,
  parameter int DW      = 16,
  localparam int IDXW   = $clog2(ENTRIES)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [IDXW-1:0] idx_i,
  input  logic            we_i,
  input  logic [DW-1:0]   wdata_i,
  output logic [DW-1:0]   rdata_o
);
  logic [DW-1:0] regs [ENTRIES];

  for (genvar g = 0; g < ENTRIES; g++) begin : g_entry
    logic hit;
    assign hit = we_i && (idx_i == IDXW'(g));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   regs[g] <= '0;
      else if (hit) regs[g] <= wdata_i;
    end
  end

  assign rdata_o = regs[idx_i];

  // R3: a write lands in the addressed entry
  a_r3_aux_write: assert property (@(posedge clk) disable iff (!rst_n)
    we_i |=> regs[$past(idx_i)] == $past(wdata_i));
endmodule

// File: rtl/ptr_core.sv
module ptr_core #(
  parameter int DW = 16,
  localparam int BW = DW / 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ld_i,
  input  logic [DW-1:0] ld_val_i,
  input  logic          hi_we_i,
  input  logic          lo_we_i,
  input  logic [BW-1:0] hi_d_i,
  input  logic [BW-1:0] lo_d_i,
  input  logic          inc_i,
  input  logic          dec_i,
  output logic [DW-1:0] ptr_o
);
  logic [DW-1:0] ptr_q, ptr_d;
  logic          byte_wr;

  assign byte_wr = hi_we_i || lo_we_i;

  always_comb begin
    ptr_d = ptr_q;
    if (ld_i) begin
      ptr_d = ld_val_i;
    end else if (byte_wr) begin
      if (hi_we_i) ptr_d[DW-1:BW] = hi_d_i;
      if (lo_we_i) ptr_d[BW-1:0]  = lo_d_i;
    end else if (inc_i) begin
      ptr_d = ptr_q + DW'(1);
    end else if (dec_i) begin
      ptr_d = ptr_q - DW'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ptr_q <= '0;
    else        ptr_q <= ptr_d;
  end

  assign ptr_o = ptr_q;

  // R11: a load overrides everything else
  a_r11_load_wins: assert property (@(posedge clk) disable iff (!rst_n)
    ld_i |=> ptr_q == $past(ld_val_i));
  // R12: high-byte write leaves the low byte alone
  a_r12_hi_only: assert property (@(posedge clk) disable iff (!rst_n)
    (!ld_i && hi_we_i && !lo_we_i) |=>
      (ptr_q[BW-1:0] == $past(ptr_q[BW-1:0])) && (ptr_q[DW-1:BW] == $past(hi_d_i)));
  // R8/R10: increment wraps modulo 2^DW
  a_r8_inc_step: assert property (@(posedge clk) disable iff (!rst_n)
    (!ld_i && !byte_wr && inc_i) |=> ptr_q == DW'($past(ptr_q) + DW'(1)));
  // R8: decrement step
  a_r8_dec_step: assert property (@(posedge clk) disable iff (!rst_n)
    (!ld_i && !byte_wr && !inc_i && dec_i) |=> ptr_q == DW'($past(ptr_q) - DW'(1)));
endmodule

// File: rtl/ptr_aux_unit.sv
module ptr_aux_unit
  import ptr_aux_pkg::*;
#(
  parameter int AUX_ENTRIES = 32,
  parameter int PW          = 16,
  parameter int SELW        = 4,
  localparam int IDXW       = $clog2(AUX_ENTRIES),
  localparam int BW         = PW / 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [2:0]      op_i,
  input  logic [IDXW-1:0] aux_idx_i,
  input  logic [2:0]      adj_i,
  input  logic [PW-1:0]   imm_i,
  input  logic            hi_we_i,
  input  logic            lo_we_i,
  input  logic [BW-1:0]   hi_wdata_i,
  input  logic [BW-1:0]   lo_wdata_i,
  input  logic            asel_vld_i,
  input  logic [SELW-1:0] asel_i,
  input  logic            ext_i,
  input  logic [1:0]      dd_i,
  output logic [PW-1:0]   ptr_o,
  output logic [PW-1:0]   aux_rd_o,
  output logic [PW-1:0]   rd_hi_addr_o,
  output logic [PW-1:0]   rd_lo_addr_o,
  output logic            mem_rd_o,
  output logic            mem_wr_o,
  output logic [PW-1:0]   mem_wr_addr_o
);
  ptr_op_e       op;
  logic          xfer_any;   // any transfer: blocks byte writes and steps
  logic          ptr_ld;     // transfer that loads the pointer
  logic [PW-1:0] ptr_ld_val;
  logic          aux_we;
  logic [PW-1:0] aux_wdata;
  logic          step_inc, step_dec;
  logic [PW-1:0] ptr_cur, aux_cur;
  logic [PW-1:0] partner;

  assign op = ptr_op_e'(op_i);

  always_comb begin
    xfer_any   = (op != OP_NONE);
    ptr_ld     = (op == OP_A2P) || (op == OP_XCHG) || (op == OP_LDI);
    ptr_ld_val = (op == OP_LDI) ? imm_i : aux_cur;
    aux_we     = (op == OP_P2A) || (op == OP_XCHG);
    aux_wdata  = apply_adjust(ptr_cur, adj_i);
  end

  ptr_step_decode #(.SELW(SELW)) u_step (
    .sel_i (asel_i),
    .vld_i (asel_vld_i),
    .ext_i (ext_i),
    .inc_o (step_inc),
    .dec_o (step_dec)
  );

  ptr_aux_file #(.ENTRIES(AUX_ENTRIES), .DW(PW)) u_file (
    .clk     (clk),
    .rst_n   (rst_n),
    .idx_i   (aux_idx_i),
    .we_i    (aux_we),
    .wdata_i (aux_wdata),
    .rdata_o (aux_cur)
  );

  ptr_core #(.DW(PW)) u_core (
    .clk      (clk),
    .rst_n    (rst_n),
    .ld_i     (ptr_ld),
    .ld_val_i (ptr_ld_val),
    .hi_we_i  (hi_we_i && !xfer_any),
    .lo_we_i  (lo_we_i && !xfer_any),
    .hi_d_i   (hi_wdata_i),
    .lo_d_i   (lo_wdata_i),
    .inc_i    (step_inc && !xfer_any),
    .dec_i    (step_dec && !xfer_any),
    .ptr_o    (ptr_cur)
  );

  assign partner       = {ptr_cur[PW-1:1], ~ptr_cur[0]};
  assign ptr_o         = ptr_cur;
  assign aux_rd_o      = aux_cur;
  assign rd_hi_addr_o  = ptr_cur;
  assign rd_lo_addr_o  = partner;
  assign mem_rd_o      = (dd_i == DD_READ);
  assign mem_wr_o      = (dd_i == DD_WR1) || (dd_i == DD_WR2);
  assign mem_wr_addr_o = (dd_i == DD_WR2) ? partner : ptr_cur;

  // R5: immediate load
  a_r5_load_imm: assert property (@(posedge clk) disable iff (!rst_n)
    op == OP_LDI |=> ptr_o == $past(imm_i));
  // R4: exchange moves the old register value into the pointer
  a_r4_xchg_ptr: assert property (@(posedge clk) disable iff (!rst_n)
    op == OP_XCHG |=> ptr_o == $past(aux_rd_o));
  // R3: pointer-to-aux leaves the pointer untouched
  a_r3_p2a_hold: assert property (@(posedge clk) disable iff (!rst_n)
    op == OP_P2A |=> $stable(ptr_o));
  // R9: extended mode holds the pointer when nothing else writes it
  a_r9_ext_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (op == OP_NONE && !hi_we_i && !lo_we_i && ext_i) |=> $stable(ptr_o));
  // R7: a write strobe never coincides with a read strobe
  a_r7_rd_wr_excl: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({mem_rd_o, mem_wr_o}));
endmodule

// File: tb/ptr_aux_unit_tb.sv
module ptr_aux_unit_tb;
  localparam int CLK_PERIOD = 10;

  logic        clk = 0;
  logic        rst_n = 0;
  logic [2:0]  op = 0;
  logic [4:0]  idx = 0;
  logic [2:0]  adj = 0;
  logic [15:0] imm = 0;
  logic        hwe = 0, lwe = 0;
  logic [7:0]  hd = 0, ld = 0;
  logic        svld = 0;
  logic [3:0]  sel = 0;
  logic        ext = 0;
  logic [1:0]  dd = 0;

  logic [15:0] ptr_o, aux_rd_o, rd_hi, rd_lo, wr_addr;
  logic        mrd, mwr;

  int checks = 0, errors = 0;
  logic [15:0] m_ptr;
  logic [15:0] m_aux [32];
  string pend_tag = "R1";
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  ptr_aux_unit u_dut (
    .clk(clk), .rst_n(rst_n), .op_i(op), .aux_idx_i(idx), .adj_i(adj),
    .imm_i(imm), .hi_we_i(hwe), .lo_we_i(lwe), .hi_wdata_i(hd), .lo_wdata_i(ld),
    .asel_vld_i(svld), .asel_i(sel), .ext_i(ext), .dd_i(dd),
    .ptr_o(ptr_o), .aux_rd_o(aux_rd_o), .rd_hi_addr_o(rd_hi), .rd_lo_addr_o(rd_lo),
    .mem_rd_o(mrd), .mem_wr_o(mwr), .mem_wr_addr_o(wr_addr)
  );

  task automatic chk(input bit ok, input string tag, input string what,
                     input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  function automatic logic [15:0] m_adjust(logic [15:0] v, logic [2:0] c);
    int amt = int'(c[1:0]);
    int r = c[2] ? int'(v) - amt : int'(v) + amt;
    return 16'((r + 65536) % 65536);
  endfunction

  function automatic int m_step(logic [3:0] s);
    if (s == 4'h8 || s == 4'h9 || s == 4'hF) return -1;
    if (s == 4'hC || s == 4'hD || s == 4'hE) return 1;
    return 0;
  endfunction

  // One clock: compare outputs against the model, then advance both.
  task automatic cyc(input string tag);
    logic [15:0] n_ptr, xw;
    logic        is_rd, is_wr;
    #1;
    chk(ptr_o == m_ptr, pend_tag, "ptr", ptr_o, m_ptr);
    chk(aux_rd_o == m_aux[idx], "R3", "aux_rd", aux_rd_o, m_aux[idx]);
    chk(rd_hi == m_ptr && rd_lo == (m_ptr ^ 16'h1), "R6", "rd_lo",
        rd_lo, m_ptr ^ 16'h1);
    is_rd = (dd == 2'b01);
    chk(mrd == is_rd, "R6", "mem_rd", 16'(mrd), 16'(is_rd));
    is_wr = dd[1];
    xw = (dd == 2'b11) ? (m_ptr ^ 16'h1) : m_ptr;
    chk(mwr == is_wr && (!is_wr || wr_addr == xw), "R7", "mem_wr_addr",
        wr_addr, xw);
    n_ptr = m_ptr;
    if (op == 3'd1 || op == 3'd3) n_ptr = m_aux[idx];
    else if (op == 3'd4) n_ptr = imm;
    else if (op == 3'd0 && (hwe || lwe)) begin
      if (hwe) n_ptr[15:8] = hd;
      if (lwe) n_ptr[7:0] = ld;
    end else if (op == 3'd0 && svld && !ext)
      n_ptr = 16'((int'(m_ptr) + m_step(sel) + 65536) % 65536);
    @(posedge clk);
    if (op == 3'd2 || op == 3'd3) m_aux[idx] = m_adjust(m_ptr, adj);
    m_ptr = n_ptr;
    pend_tag = tag;
    @(negedge clk);
  endtask

  task automatic idle();
    op = 0; hwe = 0; lwe = 0; svld = 0; ext = 0; dd = 0; adj = 0;
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    m_ptr = 0;
    foreach (m_aux[i]) m_aux[i] = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R1: reset state of the pointer and every auxiliary entry
    for (int i = 0; i < 32; i++) begin idx = 5'(i); cyc("R1"); end
    // R5 / R10: load near the top and step across the wrap
    op = 4; imm = 16'hFFFE; cyc("R5"); idle();
    sel = 4'hC; svld = 1; cyc("R10"); cyc("R10"); cyc("R10");
    sel = 4'h8; cyc("R10"); cyc("R10"); idle(); cyc("R10");
    // R8 / R9: every select code, with the mode flag clear and then set
    for (int e = 0; e < 2; e++)
      for (int s = 0; s < 16; s++) begin
        svld = 1; ext = e[0]; sel = 4'(s);
        cyc(e ? "R9" : "R8");
      end
    idle();
    // R3 / R10: every adjust code from pointer 0x0001, read back via aux_rd
    op = 4; imm = 16'h0001; cyc("R5");
    for (int a = 0; a < 8; a++) begin
      op = 2; idx = 5'(a + 3); adj = 3'(a); cyc("R3");
      op = 0; cyc("R3");
    end
    // R2: aux to pointer, adjust ignored
    op = 1; idx = 5'd9; adj = 3'b111; cyc("R2");
    // R4: exchange with an adjust
    op = 3; idx = 5'd5; adj = 3'b011; cyc("R4");
    op = 0; cyc("R4");
    op = 3; idx = 5'd5; adj = 3'b110; cyc("R4"); idle(); cyc("R4");
    // R12: single-byte and two-byte writes
    hwe = 1; hd = 8'hA5; cyc("R12"); hwe = 0;
    lwe = 1; ld = 8'h3C; cyc("R12");
    hwe = 1; hd = 8'h12; ld = 8'h34; cyc("R12"); idle();
    // R11: priority between transfer, byte write and step
    op = 4; imm = 16'h7777; hwe = 1; hd = 8'h00; svld = 1; sel = 4'hC; cyc("R11");
    op = 0; lwe = 1; ld = 8'h99; cyc("R11");
    op = 2; idx = 5'd0; hwe = 0; lwe = 1; cyc("R11"); idle(); cyc("R11");
    // R6 / R7: every access kind at an even and an odd pointer
    for (int p = 0; p < 2; p++) begin
      op = 4; imm = 16'h4000 + 16'(p); cyc("R5"); op = 0;
      for (int d = 0; d < 4; d++) begin dd = 2'(d); cyc("R7"); end
    end
    idle();
    // random mix against the model
    for (int n = 0; n < 4000; n++) begin
      op = 3'($urandom_range(0, 4));
      idx = 5'($urandom); adj = 3'($urandom); imm = 16'($urandom);
      hwe = ($urandom_range(0, 5) == 0); lwe = ($urandom_range(0, 5) == 0);
      hd = 8'($urandom); ld = 8'($urandom);
      svld = 1'($urandom); sel = 4'($urandom); ext = ($urandom_range(0, 3) == 0);
      dd = 2'($urandom);
      cyc("R11");
    end
    idle(); cyc("R11");
    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule